// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This engine sits beside a byte-oriented configuration item store and moves whole blocks of item bytes to or from system memory without per-byte register traffic. Software places a 16-byte descriptor in memory and writes its address into a 64-bit big-endian address register. The write to the low half starts the operation. The engine fetches the descriptor, optionally selects a new item, performs one read, write or skip on the selected item, and then overwrites the descriptor's control word with a completion status.

The register side is a small write-only slave with a busy output. The memory side is a byte-wide master that holds each request until it is acknowledged. The item side exposes the current item key and byte offset to the store, and the store answers combinationally with the byte at that offset, the item size and a read-only flag. The engine owns the key and offset state, so that state can be observed at the item port.

Top module: `cfgdma_engine`

## Requirements
- R1: The address register is two 32-bit halves and resets to zero. The half with `regSelLow` = 0 holds bits 63:32 and the half with `regSelLow` = 1 holds bits 31:0. In each written word, `regWdata[7:0]` is the most significant byte of that half and `regWdata[31:24]` is the least significant byte. A write to the upper half only stores the value, and the upper half keeps that value for later operations.
- R2: A write to the low half while idle starts an operation. The engine reads 16 descriptor bytes at ascending addresses from the register address. Bytes 0-3 are the control word, bytes 4-7 are the length and bytes 8-15 are the data address, each field most significant byte first.
- R3: `regBusy` is high from the clock edge that accepts the trigger until the status write finishes. Any register write made while busy is dropped: it neither changes the address nor starts another operation.
- R4: If control bit 3 is set, control bits 31:16 become the item key and the offset is cleared, before any transfer takes place.
- R5: If control bit 1 is set, `length` item bytes, starting at the current offset, are written to memory at ascending addresses from the data address. The offset advances by one per byte.
- R6: A read byte whose offset is at or past the item size is written to memory as zero. Such a read still ends with success status.
- R7: If control bit 4 is set and bit 1 is clear, `length` memory bytes are copied into the item at ascending offsets. When bits 1 and 4 are both set, the operation is a read.
- R8: A write whose offset plus length exceeds the item size, or whose target item is read-only, changes no item byte, reads no data from memory and leaves the offset unchanged. It ends with error status.
- R9: If control bit 2 is set and bits 1 and 4 are clear, the offset advances by `length` and no data byte moves.
- R10: When the operation ends, the engine writes 4 bytes to the descriptor address, most significant byte first. The word is 0x00000000 on success and 0x00000001 (bit 0 = error) on failure.
- R11: `memReq` stays high, with `memAddr` and `memWe` unchanged, until the cycle in which `memAck` is sampled high.
- R12: Control bit 0 on input is ignored. A control word with none of bits 1, 2 or 4 set, or a length of zero, moves no data and reports success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSelLow | input | 1 | 1 = low address half (trigger), 0 = upper half |
| regWdata | input | 32 | Register write data, big-endian byte lanes |
| regBusy | output | 1 | Operation in progress |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | 64 | Memory byte address |
| memWdata | output | 8 | Memory write byte |
| memRdata | input | 8 | Memory read byte, valid with memAck |
| memAck | input | 1 | Memory acknowledge |
| itemKey | output | 16 | Currently selected item key |
| itemOffset | output | 32 | Current byte offset in the item |
| itemRdata | input | 8 | Item byte at itemKey/itemOffset |
| itemSize | input | 32 | Size in bytes of the selected item |
| itemRo | input | 1 | Selected item is read-only |
| itemWe | output | 1 | Item byte write strobe |
| itemWdata | output | 8 | Item write byte |

## Verification
The bench aims at item boundaries. A read that crosses the end of an item must zero-fill the bytes past the end; a design that indexes the store past the end would copy garbage into memory. A write that lands exactly on the last byte must be accepted, and a write one byte longer must be rejected; an off-by-one in the bound test would either corrupt the item or refuse a legal transfer. The bench also aims at operation state. It starts a second trigger while busy, which a design without the busy gate would execute, and it uses a descriptor address above 4 GiB, which a design that drops the upper half would fetch from the wrong place. It also checks skip followed by a read without a new select, which exposes any offset that is reset or advanced wrongly.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  localparam int ADDR_W     = 64;
  localparam int WORD_W     = 32;
  localparam int KEY_W      = 16;
  localparam int DESC_BYTES = 16;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int WB_BYTES   = WORD_W / 8;

  // control word bit positions
  localparam int CTL_ERR  = 0;
  localparam int CTL_RD   = 1;
  localparam int CTL_SKIP = 2;
  localparam int CTL_SEL  = 3;
  localparam int CTL_WR   = 4;

  typedef enum logic [1:0] {SRC_DESC, SRC_DATA, SRC_WB} addr_src_e;

  typedef struct packed {
    logic      descShift;
    logic      loadSel;
    logic      offInc;
    logic      offSkip;
    logic      setErr;
    logic      clrErr;
    addr_src_e addrSrc;
  } dma_strb_t;

  function automatic logic [WORD_W-1:0] laneSwap(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WB_BYTES; b++)
      r[b*8 +: 8] = w[(WB_BYTES-1-b)*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfgdma_dp.sv
module cfgdma_dp
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regSelLow,
  input  logic [WORD_W-1:0] regWdata,
  input  logic              busy,
  input  dma_strb_t         strb,
  input  logic [WORD_W-1:0] cnt,
  input  logic [7:0]        memRdata,
  input  logic [7:0]        itemRdata,
  input  logic [WORD_W-1:0] itemSize,
  input  logic              itemRo,
  output logic              trig,
  output logic              opRd,
  output logic              opWr,
  output logic              opSkip,
  output logic              opSel,
  output logic [WORD_W-1:0] lenWord,
  output logic              writeBad,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [KEY_W-1:0]  curKey,
  output logic [WORD_W-1:0] curOffset
);
  logic [ADDR_W-1:0] addrReg;
  logic [DESC_W-1:0] desc;
  logic [WORD_W-1:0] ctlWord;
  logic [ADDR_W-1:0] dataAddr;
  logic              errFlag;
  logic [7:0]        readByte;
  logic              unusedBits;

  assign trig = regWe && regSelLow && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) addrReg <= '0;
    else if (regWe && !busy) begin
      if (regSelLow) addrReg[WORD_W-1:0]      <= laneSwap(regWdata);
      else           addrReg[ADDR_W-1:WORD_W] <= laneSwap(regWdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) desc <= '0;
    else if (strb.descShift) desc <= {desc[DESC_W-9:0], memRdata};
  end

  assign ctlWord  = desc[DESC_W-1 -: WORD_W];
  assign lenWord  = desc[DESC_W-WORD_W-1 -: WORD_W];
  assign dataAddr = desc[ADDR_W-1:0];
  assign opRd     = ctlWord[CTL_RD];
  assign opWr     = ctlWord[CTL_WR];
  assign opSkip   = ctlWord[CTL_SKIP];
  assign opSel    = ctlWord[CTL_SEL];
  assign unusedBits = ^{ctlWord[KEY_W-1:CTL_WR+1], ctlWord[CTL_ERR]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curKey    <= '0;
      curOffset <= '0;
    end else if (strb.loadSel) begin
      curKey    <= ctlWord[WORD_W-1 -: KEY_W];
      curOffset <= '0;
    end else if (strb.offInc) begin
      curOffset <= curOffset + 1'b1;
    end else if (strb.offSkip) begin
      curOffset <= curOffset + lenWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrErr) errFlag <= 1'b0;
    else if (strb.setErr)     errFlag <= 1'b1;
  end

  assign writeBad = itemRo ||
                    (({1'b0, curOffset} + {1'b0, lenWord}) > {1'b0, itemSize});
  assign readByte = (curOffset < itemSize) ? itemRdata : 8'h00;

  always_comb begin
    memAddr  = addrReg + ADDR_W'(cnt);
    memWdata = 8'h00;
    unique case (strb.addrSrc)
      SRC_DATA: begin
        memAddr  = dataAddr + ADDR_W'(cnt);
        memWdata = readByte;
      end
      SRC_WB: begin
        if (errFlag && cnt == WORD_W'(WB_BYTES-1)) memWdata = 8'(1 << CTL_ERR);
      end
      default: ;
    endcase
  end

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe) |=> $stable(addrReg));

  // R4
  key_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadSel |=> $stable(curKey));
endmodule

// File: rtl/cfgdma_ctrl.sv
module cfgdma_ctrl
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trig,
  input  logic              opRd,
  input  logic              opWr,
  input  logic              opSkip,
  input  logic              opSel,
  input  logic [WORD_W-1:0] lenWord,
  input  logic              writeBad,
  input  logic              memAck,
  output logic              busy,
  output dma_strb_t         strb,
  output logic [WORD_W-1:0] cnt,
  output logic              memReq,
  output logic              memWe,
  output logic              itemWe
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_EXEC, S_XRD, S_XWR, S_WBACK
  } st_e;

  st_e               state, stateNx;
  logic [WORD_W-1:0] cntNx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNx;
      cnt   <= cntNx;
    end
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    stateNx      = state;
    cntNx        = cnt;
    strb         = '0;
    strb.addrSrc = SRC_DESC;
    memReq       = 1'b0;
    memWe        = 1'b0;
    itemWe       = 1'b0;
    unique case (state)
      S_IDLE: if (trig) begin
        strb.clrErr = 1'b1;
        cntNx       = '0;
        stateNx     = S_FETCH;
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.descShift = 1'b1;
          if (cnt == WORD_W'(DESC_BYTES-1)) begin
            cntNx   = '0;
            stateNx = S_DECODE;
          end else cntNx = cnt + 1'b1;
        end
      end
      S_DECODE: begin
        strb.loadSel = opSel;
        stateNx      = S_EXEC;
      end
      S_EXEC: begin
        if (opRd) stateNx = (lenWord == '0) ? S_WBACK : S_XRD;
        else if (opWr) begin
          if (writeBad) begin
            strb.setErr = 1'b1;
            stateNx     = S_WBACK;
          end else stateNx = (lenWord == '0) ? S_WBACK : S_XWR;
        end else begin
          strb.offSkip = opSkip;
          stateNx      = S_WBACK;
        end
      end
      S_XRD, S_XWR: begin
        memReq       = 1'b1;
        memWe        = (state == S_XRD);
        strb.addrSrc = SRC_DATA;
        if (memAck) begin
          strb.offInc = 1'b1;
          itemWe      = (state == S_XWR);
          if (cnt + 1'b1 == lenWord) begin
            cntNx   = '0;
            stateNx = S_WBACK;
          end else cntNx = cnt + 1'b1;
        end
      end
      S_WBACK: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.addrSrc = SRC_WB;
        if (memAck) begin
          if (cnt == WORD_W'(WB_BYTES-1)) begin
            cntNx   = '0;
            stateNx = S_IDLE;
          end else cntNx = cnt + 1'b1;
        end
      end
      default: stateNx = S_IDLE;
    endcase
  end

  // R8
  reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EXEC && opWr && !opRd && writeBad) |=> (state == S_WBACK));

  // R3
  no_early_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(state == S_WBACK && memAck)) |=> busy);
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regSelLow,
  input  logic [31:0] regWdata,
  output logic        regBusy,
  output logic        memReq,
  output logic        memWe,
  output logic [63:0] memAddr,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  input  logic        memAck,
  output logic [15:0] itemKey,
  output logic [31:0] itemOffset,
  input  logic [7:0]  itemRdata,
  input  logic [31:0] itemSize,
  input  logic        itemRo,
  output logic        itemWe,
  output logic [7:0]  itemWdata
);
  dma_strb_t         strb;
  logic [WORD_W-1:0] cnt;
  logic [WORD_W-1:0] lenWord;
  logic              trig, opRd, opWr, opSkip, opSel, writeBad;

  cfgdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trig(trig),
    .opRd(opRd), .opWr(opWr), .opSkip(opSkip), .opSel(opSel),
    .lenWord(lenWord), .writeBad(writeBad), .memAck(memAck),
    .busy(regBusy), .strb(strb), .cnt(cnt),
    .memReq(memReq), .memWe(memWe), .itemWe(itemWe)
  );

  cfgdma_dp u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSelLow(regSelLow),
    .regWdata(regWdata), .busy(regBusy), .strb(strb), .cnt(cnt),
    .memRdata(memRdata), .itemRdata(itemRdata), .itemSize(itemSize),
    .itemRo(itemRo), .trig(trig), .opRd(opRd), .opWr(opWr),
    .opSkip(opSkip), .opSel(opSel), .lenWord(lenWord), .writeBad(writeBad),
    .memAddr(memAddr), .memWdata(memWdata), .curKey(itemKey),
    .curOffset(itemOffset)
  );

  assign itemWdata = memRdata;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R8
  item_write_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    itemWe |-> (!itemRo && itemOffset < itemSize));

  // R10
  wb_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && strb.addrSrc == SRC_WB && cnt != WORD_W'(WB_BYTES-1)) |-> (memWdata == 8'h00));

  // R9
  no_item_write_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regBusy |-> !itemWe && !memReq);
endmodule

// File: tb/sim_cfgdma_engine.sv
module sim_cfgdma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        regWe = 1'b0, regSelLow = 1'b0;
  logic [31:0] regWdata = '0;
  logic        regBusy, memReq, memWe, itemWe, itemRo;
  logic [63:0] memAddr;
  logic [7:0]  memWdata, itemWdata, itemRdata;
  logic [7:0]  memRdata = '0;
  logic        memAck = 1'b0;
  logic [15:0] itemKey;
  logic [31:0] itemOffset, itemSize;

  cfgdma_engine u0 (.*);

  logic [7:0]  mem     [0:255];
  logic [7:0]  refMem  [0:255];
  logic [7:0]  itemMem [0:3][0:31];
  logic [7:0]  refItem [0:3][0:31];
  int          sizeTab [0:3] = '{20, 8, 32, 12};
  bit          roTab   [0:3] = '{1'b0, 1'b1, 1'b0, 1'b0};
  logic [55:0] expHi = '0;
  logic [31:0] curHi = '0;
  logic [15:0] refKey = '0;
  logic [31:0] refOff = '0;
  int hiErr = 0, nReq = 0, nChk = 0, nBad = 0, cyc = 0;

  assign itemSize  = (itemKey < 16'd4) ? 32'(sizeTab[itemKey[1:0]]) : 32'd0;
  assign itemRo    = (itemKey < 16'd4) ? roTab[itemKey[1:0]] : 1'b0;
  assign itemRdata = (itemKey < 16'd4 && itemOffset < 32'd32) ?
                     itemMem[itemKey[1:0]][itemOffset[4:0]] : 8'h00;

  // memory responder: random latency, acts at the falling edge
  initial forever begin
    @(negedge clk);
    if (memAck) memAck = 1'b0;
    else if (memReq && ($urandom_range(2, 0) != 0)) begin
      if (memAddr[63:8] != expHi) hiErr++;
      if (memWe) mem[memAddr[7:0]] = memWdata;
      else       memRdata = mem[memAddr[7:0]];
      memAck = 1'b1;
      nReq++;
    end
  end

  // item store write port
  initial forever begin
    @(posedge clk);
    if (itemWe && itemKey < 16'd4 && itemOffset < 32'd32)
      itemMem[itemKey[1:0]][itemOffset[4:0]] <= itemWdata;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
    if (cyc > WATCHDOG) begin
      nChk++; nBad++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic regWrite(input bit low, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regSelLow = low; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    mem[a] = d; refMem[a] = d;
  endtask

  task automatic putDesc(input logic [7:0] base, input logic [31:0] ctl,
                         input logic [31:0] len, input logic [63:0] xa);
    for (int i = 0; i < 4; i++) begin
      poke(base + 8'(i),     ctl[31-8*i -: 8]);
      poke(base + 8'(4 + i), len[31-8*i -: 8]);
    end
    for (int i = 0; i < 8; i++) poke(base + 8'(8 + i), xa[63-8*i -: 8]);
  endtask

  function automatic int refSize(input logic [15:0] k);
    return (k < 16'd4) ? sizeTab[k[1:0]] : 0;
  endfunction

  task automatic runOp(input logic [63:0] da, input logic [31:0] ctl, input logic [31:0] len,
                       input logic [63:0] xa, input int injectAt, input logic [7:0] injLo,
                       input string tag);
    bit   err;
    int   k;
    putDesc(da[7:0], ctl, len, xa);
    if (da[63:32] != curHi) begin
      regWrite(1'b0, bswap(da[63:32]));
      curHi = da[63:32];
    end
    expHi = da[63:8];
    regWrite(1'b1, bswap(da[31:0]));
    check(regBusy == 1'b1, {tag, " R3 busy after trigger"}, 64'(regBusy), 64'd1);
    if (injectAt >= 0) begin
      repeat (injectAt) @(negedge clk);
      regWrite(1'b1, bswap({24'h0, injLo}));
      check(regBusy == 1'b1, {tag, " R3 busy during second trigger"}, 64'(regBusy), 64'd1);
    end
    k = 0;
    while (regBusy && k < 5000) begin @(negedge clk); k++; end
    check(!regBusy, {tag, " R3 operation completes"}, 64'(regBusy), 64'd0);
    // reference model
    err = 1'b0;
    if (ctl[3]) begin refKey = ctl[31:16]; refOff = '0; end
    if (ctl[1]) begin
      for (int i = 0; i < int'(len); i++) begin
        refMem[xa[7:0] + 8'(i)] = (refOff < 32'(refSize(refKey))) ?
                                  refItem[refKey[1:0]][refOff[4:0]] : 8'h00;
        refOff++;
      end
    end else if (ctl[4]) begin
      if ((refKey < 16'd4 && roTab[refKey[1:0]]) ||
          (33'(refOff) + 33'(len) > 33'(refSize(refKey)))) err = 1'b1;
      else for (int i = 0; i < int'(len); i++) begin
        refItem[refKey[1:0]][refOff[4:0]] = refMem[xa[7:0] + 8'(i)];
        refOff++;
      end
    end else if (ctl[2]) refOff = refOff + len;
    for (int i = 0; i < 4; i++) refMem[da[7:0] + 8'(i)] = (i == 3) ? {7'b0, err} : 8'h00;
    // compare
    begin
      int bad = -1;
      for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== refMem[i]) bad = i;
      check(bad < 0, {tag, " R10 memory image"}, (bad < 0) ? 64'd0 : 64'(mem[bad]),
            (bad < 0) ? 64'd0 : 64'(refMem[bad]));
    end
    begin
      int bad = -1;
      for (int i = 0; i < 128; i++)
        if (bad < 0 && itemMem[i/32][i%32] !== refItem[i/32][i%32]) bad = i;
      check(bad < 0, {tag, " R7 item image"}, (bad < 0) ? 64'd0 : 64'(itemMem[bad/32][bad%32]),
            (bad < 0) ? 64'd0 : 64'(refItem[bad/32][bad%32]));
    end
    check(itemKey == refKey, {tag, " R4 item key"}, 64'(itemKey), 64'(refKey));
    check(itemOffset == refOff, {tag, " R9 item offset"}, 64'(itemOffset), 64'(refOff));
    check(hiErr == 0, {tag, " R1 upper address bits"}, 64'(hiErr), 64'd0);
  endtask

  initial begin
    int reqBefore;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'($urandom); refMem[i] = mem[i]; end
    for (int i = 0; i < 128; i++) begin
      itemMem[i/32][i%32] = 8'(i * 7 + 3);
      refItem[i/32][i%32] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!regBusy && !memReq, "R3 reset idle", {62'b0, regBusy, memReq}, 64'd0);
    check(itemKey == 16'd0 && itemOffset == 32'd0, "R4 reset key/offset",
          {16'b0, itemKey, itemOffset}, 64'd0);

    // R1: upper-half write alone must not start anything
    reqBefore = nReq;
    regWrite(1'b0, bswap(32'h0000_0001));
    curHi = 32'h0000_0001;
    repeat (20) @(negedge clk);
    check(!regBusy && nReq == reqBefore, "R1 upper write only latches",
          64'(nReq - reqBefore), 64'd0);
    // R1 R2: 64-bit descriptor address, upper half kept from the write above
    runOp(64'h1_0000_0040, 32'h0002_0008 | 32'h2, 32'd10, 64'h1_0000_0090, -1, 8'h0, "R1 R2 R5 high address");
    // R4 R5: select and read within item
    runOp(64'h0000_0000, 32'h0000_000A, 32'd16, 64'h80, -1, 8'h0, "R4 R5 read");
    // R6: read across end of 8-byte item
    runOp(64'h0000_0010, 32'h0001_000A, 32'd12, 64'hA0, -1, 8'h0, "R6 zero fill");
    // R6: unknown key, every byte zero
    runOp(64'h0000_0020, 32'h4000_000A, 32'd5, 64'hB0, -1, 8'h0, "R6 unknown key");
    // R7: write into item 2
    runOp(64'h0000_0000, 32'h0002_0018, 32'd10, 64'hC0, -1, 8'h0, "R7 write");
    // R8: write to read-only item
    runOp(64'h0000_0010, 32'h0001_0018, 32'd2, 64'hC0, -1, 8'h0, "R8 read-only");
    // R9 then R8: skip to 15 in item 0, then overflowing write, then exact fit
    runOp(64'h0000_0020, 32'h0000_000C, 32'd15, 64'h80, -1, 8'h0, "R9 skip");
    runOp(64'h0000_0030, 32'h0000_0010, 32'd6, 64'hD0, -1, 8'h0, "R8 overflow");
    runOp(64'h0000_0000, 32'h0000_0010, 32'd5, 64'hD0, -1, 8'h0, "R8 exact fit");
    // R9: skip then read without reselect
    runOp(64'h0000_0010, 32'h0003_000C, 32'd7, 64'h80, -1, 8'h0, "R9 skip item3");
    runOp(64'h0000_0020, 32'h0000_0002, 32'd3, 64'hE0, -1, 8'h0, "R9 continue");
    // R12: error bit in, no op; zero-length write
    runOp(64'h0000_0030, 32'h0002_0009, 32'd4, 64'h80, -1, 8'h0, "R12 no op");
    runOp(64'h0000_0000, 32'h0000_0010, 32'd0, 64'h80, -1, 8'h0, "R12 zero length");
    // R7: read and write bits both set acts as read
    runOp(64'h0000_0010, 32'h0000_001A, 32'd4, 64'hF0, -1, 8'h0, "R7 read wins");
    // R3: second trigger while busy is dropped
    putDesc(8'h30, 32'h0003_000A, 32'd4, 64'hC8);
    runOp(64'h0000_0000, 32'h0002_000A, 32'd20, 64'h80, 6, 8'h30, "R3 busy ignore");
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [31:0] ctl;
      int op;
      op  = $urandom_range(3, 0);
      ctl = {16'($urandom_range(3, 0)), 11'b0, op == 1, ($urandom_range(2, 0) != 0),
             op == 2, op == 0, 1'($urandom)};
      runOp(64'(16 * $urandom_range(3, 0)), ctl, 32'($urandom_range(24, 0)),
            64'(8'h80 + 8'($urandom_range(63, 0))), -1, 8'h0, "R2 R5 R7 R9 random");
    end
    summary();
    $finish;
  end
endmodule